// File: doc/BRIEF.md
# Synchronous CPU clock stop controller

This block gates a set of CPU differential clock lanes from a single active-low stop request while the rest of the clock generator keeps running. It generates the internal CPU clock phase from `clk_i` (one CPU period is two `clk_i` cycles) and drives, per lane, a true level, a complement level and an output-enable for each leg. A per-lane mask selects which lanes may be stopped.

The stop request is synchronized, then qualified on the edges where the internal complement clock rises. It takes effect only after it has been seen on two such edges in a row. After a programmable wait, each stoppable lane parks at an edge where the internal true clock rises. A parked lane holds its true leg driven high and its complement leg low with its driver released. Restart happens at an edge where the internal true clock falls, so every pulse on a lane keeps its full width.

Top module: `cpu_clk_stop_ctrl`

## Requirements
- R1: After reset, `stopped_o` is all zero and every lane runs: `clk_t_o` starts low and toggles on every `clk_i` edge, and `clk_c_o` is its inverse.
- R2: `stop_ni` passes two synchronizer flops. It qualifies only when the synchronized value is low at two consecutive sample edges, where a sample edge is one at which the internal true clock falls. A low pulse that covers a single sample edge has no effect on any lane.
- R3: With `STOP_WAIT` = W, a stoppable lane parks on the 2W+6th or 2W+7th `clk_i` edge after `stop_ni` falls. This is W+0.5 CPU periods after the second qualifying sample, so W in 2..5 keeps it within 2 to 6 periods.
- R4: A parked lane drives `clk_t_o`=1 and `clk_c_o`=0. Parking begins only at an edge where the internal true clock rises.
- R5: `oe_t_o` is always 1. `oe_c_o[k]` is 0 exactly while lane k is parked.
- R6: A lane with `stoppable_i[k]`=0 never parks. If its bit is cleared while it is parked, the lane resumes at the next edge where the internal true clock falls.
- R7: After `stop_ni` rises, every parked lane resumes on the 3rd or 4th `clk_i` edge, which is within two CPU periods.
- R8: No lane shows a short or stretched pulse. Every low interval of `clk_t_o` lasts exactly one `clk_i` cycle, and every high interval lasts an odd number of cycles.
- R9: `stopped_o[k]` is 1 exactly while lane k is parked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock at twice the CPU output frequency |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stop_ni | input | 1 | Asynchronous stop request, active low |
| stoppable_i | input | NUM_LANES | Per-lane stop enable |
| clk_t_o | output | NUM_LANES | True leg level |
| clk_c_o | output | NUM_LANES | Complement leg level |
| oe_t_o | output | NUM_LANES | True leg drive enable |
| oe_c_o | output | NUM_LANES | Complement leg drive enable |
| stopped_o | output | NUM_LANES | Lane parked status |

## Verification
Park is due on edge 2W+6 or 2W+7 after the stop input falls; which one depends on the phase at the time of the change. Release is due on edge 3 or 4 after the input rises. The bench counts `clk_i` edges from the negedge at which it changes `stop_ni` and accepts exactly that window. A behavioural model advances once per rising edge, and its expected levels, enables and status are compared with the outputs on every falling edge, half a cycle after the registers update. Pulse widths are measured on every lane at falling edges, so a clipped or stretched half cycle shows up as a wrong run length.

// File: rtl/cpu_stop_pkg.sv
package cpu_stop_pkg;
  localparam int unsigned SYNC_STAGES = 2;

  typedef struct packed {
    logic t;
    logic c;
    logic oe_t;
    logic oe_c;
  } lane_drv_t;
endpackage

// File: rtl/stop_sync.sv
module stop_sync
  import cpu_stop_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_ni,
  output logic sync_no
);
  logic [SYNC_STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], async_ni};
  end

  assign sync_no = sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/stop_qualifier.sv
module stop_qualifier #(
  parameter int unsigned STOP_WAIT = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stop_sync_ni,
  output logic phase_o,
  output logic gate_o
);
  localparam int unsigned CW = $clog2(STOP_WAIT + 1);
  localparam logic [CW-1:0] WAIT_END = CW'(STOP_WAIT);

  logic          phase_q;
  logic [1:0]    hist_q;
  logic [CW-1:0] wait_q;
  logic          seen;

  assign seen = &hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      hist_q  <= '0;
      wait_q  <= '0;
    end else begin
      phase_q <= ~phase_q;
      // release has priority over sampling
      if (stop_sync_ni)  hist_q <= '0;
      else if (phase_q)  hist_q <= {hist_q[0], 1'b1};
      if (!seen)                             wait_q <= '0;
      else if (phase_q && wait_q != WAIT_END) wait_q <= wait_q + 1'b1;
    end
  end

  assign phase_o = phase_q;
  assign gate_o  = seen && (wait_q == WAIT_END) && !stop_sync_ni;

  // R2: qualification completes only at a sample edge with the input low
  a_r2_qualify_on_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(seen) |-> ($past(phase_q) && !$past(stop_sync_ni)));

  // R3: gate never opens before the wait has run
  a_r3_wait_before_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_o) |-> $past(seen));
endmodule

// File: rtl/lane_gate.sv
module lane_gate
  import cpu_stop_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      phase_i,
  input  logic      gate_i,
  input  logic      stoppable_i,
  output lane_drv_t drv_o,
  output logic      stopped_o
);
  logic stopped_q;
  logic target;

  assign target = gate_i && stoppable_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  stopped_q <= 1'b0;
    else if (!phase_i &&  target) stopped_q <= 1'b1; // true clock about to rise
    else if ( phase_i && !target) stopped_q <= 1'b0; // true clock about to fall
  end

  always_comb begin
    drv_o.t    = stopped_q ? 1'b1 : phase_i;
    drv_o.c    = stopped_q ? 1'b0 : ~phase_i;
    drv_o.oe_t = 1'b1;
    drv_o.oe_c = ~stopped_q;
  end
  assign stopped_o = stopped_q;

  a_r4_park_on_true_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stopped_q) |-> (phase_i && !$past(phase_i)));

  a_r8_resume_on_true_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(stopped_q) |-> (!phase_i && $past(phase_i)));

  a_r6_free_lane_runs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stoppable_i && !stopped_q) |=> !stopped_q);
endmodule

// File: rtl/cpu_clk_stop_ctrl.sv
module cpu_clk_stop_ctrl
  import cpu_stop_pkg::*;
#(
  parameter int unsigned NUM_LANES = 4,
  parameter int unsigned STOP_WAIT = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 stop_ni,
  input  logic [NUM_LANES-1:0] stoppable_i,
  output logic [NUM_LANES-1:0] clk_t_o,
  output logic [NUM_LANES-1:0] clk_c_o,
  output logic [NUM_LANES-1:0] oe_t_o,
  output logic [NUM_LANES-1:0] oe_c_o,
  output logic [NUM_LANES-1:0] stopped_o
);
  logic stop_sync_n;
  logic phase;
  logic gate;

  stop_sync u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .async_ni (stop_ni),
    .sync_no  (stop_sync_n)
  );

  stop_qualifier #(.STOP_WAIT(STOP_WAIT)) u_qual (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .stop_sync_ni (stop_sync_n),
    .phase_o      (phase),
    .gate_o       (gate)
  );

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
    lane_drv_t drv;
    lane_gate u_lane (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .phase_i     (phase),
      .gate_i      (gate),
      .stoppable_i (stoppable_i[k]),
      .drv_o       (drv),
      .stopped_o   (stopped_o[k])
    );
    assign clk_t_o[k] = drv.t;
    assign clk_c_o[k] = drv.c;
    assign oe_t_o[k]  = drv.oe_t;
    assign oe_c_o[k]  = drv.oe_c;
  end

  // R7: two released synchronizer samples leave no lane parked
  a_r7_release_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(stop_sync_n) && $past(stop_sync_n, 2)) |-> (stopped_o == '0));

  // R5: complement driver is off exactly on parked lanes
  a_r5_oe_tracks_park: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_c_o == ~stopped_o) && (oe_t_o == '1));
endmodule

// File: tb/sim_cpu_clk_stop_ctrl.sv
module sim_cpu_clk_stop_ctrl;
  localparam int N = 4;
  localparam int W = 2;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         stop_ni = 1'b1;
  logic [N-1:0] stoppable_i = '0;
  logic [N-1:0] clk_t_o, clk_c_o, oe_t_o, oe_c_o, stopped_o;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  cpu_clk_stop_ctrl #(.NUM_LANES(N), .STOP_WAIT(W)) u0 (
    .clk_i, .rst_ni, .stop_ni, .stoppable_i,
    .clk_t_o, .clk_c_o, .oe_t_o, .oe_c_o, .stopped_o
  );

  always #5 clk_i = ~clk_i;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // behavioural reference, advanced once per rising edge
  int m_ph, m_in1, m_in2, m_lows, m_wait;
  int m_park[N];
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_ph = 0; m_in1 = 1; m_in2 = 1; m_lows = 0; m_wait = 0;
      foreach (m_park[k]) m_park[k] = 0;
    end else begin
      int syn;
      bit go;
      syn = m_in2;
      go = (m_lows >= 2) && (m_wait == W) && (syn == 0);
      foreach (m_park[k]) begin
        if (m_ph == 0 && go && stoppable_i[k]) m_park[k] = 1;
        else if (m_ph == 1 && !(go && stoppable_i[k])) m_park[k] = 0;
      end
      if (m_lows < 2) m_wait = 0;
      else if (m_ph == 1 && m_wait < W) m_wait++;
      if (syn == 1) m_lows = 0;
      else if (m_ph == 1 && m_lows < 2) m_lows++;
      m_ph = 1 - m_ph;
      m_in2 = m_in1;
      m_in1 = int'(stop_ni);
    end
  end

  // per-cycle comparison and pulse-width tracking
  int lo_run[N];
  int hi_run[N];
  always @(negedge clk_i) begin
    cyc++;
    if (rst_ni) begin
      for (int k = 0; k < N; k++) begin
        int et, ec;
        et = m_park[k] ? 1 : m_ph;
        ec = m_park[k] ? 0 : 1 - m_ph;
        check(clk_t_o[k] == et, "R4 clk_t_o", clk_t_o[k], et);
        check(clk_c_o[k] == ec, "R4 clk_c_o", clk_c_o[k], ec);
        check(oe_t_o[k] == 1'b1, "R5 oe_t_o", oe_t_o[k], 1);
        check(oe_c_o[k] == !m_park[k], "R5 oe_c_o", oe_c_o[k], !m_park[k]);
        check(stopped_o[k] == m_park[k], "R9 stopped_o", stopped_o[k], m_park[k]);
        if (clk_t_o[k]) begin
          if (lo_run[k] > 0) check(lo_run[k] == 1, "R8 low width", lo_run[k], 1);
          lo_run[k] = 0;
          hi_run[k]++;
        end else begin
          if (hi_run[k] > 0) check(hi_run[k] % 2 == 1, "R8 high width odd", hi_run[k], 1);
          hi_run[k] = 0;
          lo_run[k]++;
        end
      end
    end
    if (cyc > 100000) begin
      check(0, "watchdog", cyc, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic stop_and_measure(input int lane);
    int lat = 0;
    stop_ni = 1'b0;
    while (lat < 40) begin
      @(negedge clk_i); lat++;
      if (stopped_o[lane]) break;
    end
    check(lat >= 2*W+6 && lat <= 2*W+7, "R3 park latency", lat, 2*W+6);
  endtask

  task automatic release_and_measure(input int lane);
    int lat = 0;
    stop_ni = 1'b1;
    while (lat < 40) begin
      @(negedge clk_i); lat++;
      if (!stopped_o[lane]) break;
    end
    check(lat >= 3 && lat <= 4, "R7 resume latency", lat, 3);
  endtask

  initial begin
    foreach (lo_run[k]) begin lo_run[k] = 0; hi_run[k] = 0; end
    repeat (3) @(negedge clk_i);
    check(stopped_o == '0, "R1 reset stopped_o", stopped_o, 0);
    check(clk_t_o == '0 && clk_c_o == '1, "R1 reset levels", clk_t_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(clk_t_o == '1, "R1 first toggle", clk_t_o, 15);

    // masked lanes 0 and 2
    stoppable_i = 4'b0101;
    repeat (5) @(negedge clk_i);
    stop_and_measure(0);
    repeat (20) @(negedge clk_i);
    check(stopped_o == 4'b0101, "R6 only stoppable lanes park", stopped_o, 5);
    check(clk_t_o[0] && !clk_c_o[0], "R4 parked levels", clk_t_o[0], 1);
    release_and_measure(0);
    repeat (4) @(negedge clk_i);

    // other phase alignment, all lanes
    stoppable_i = '1;
    @(negedge clk_i);
    stop_and_measure(3);
    check(stopped_o == '1, "R3 all lanes park together", stopped_o, 15);
    repeat (7) @(negedge clk_i);
    release_and_measure(3);
    check(stopped_o == '0, "R7 all lanes resumed", stopped_o, 0);

    // short pulse covering one sample edge
    repeat (6) @(negedge clk_i);
    stop_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    stop_ni = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk_i);
      check(stopped_o == '0, "R2 single sample ignored", stopped_o, 0);
    end

    // clear a mask bit while parked
    stop_and_measure(1);
    repeat (3) @(negedge clk_i);
    stoppable_i = 4'b1110;
    repeat (3) @(negedge clk_i);
    check(stopped_o == 4'b1110, "R6 unmasked lane resumes", stopped_o, 14);
    repeat (5) @(negedge clk_i);
    release_and_measure(1);

    // a few pulses of varying width
    for (int w = 1; w < 16; w += 3) begin
      stop_ni = 1'b0;
      repeat (w) @(negedge clk_i);
      stop_ni = 1'b1;
      repeat (9) @(negedge clk_i);
    end
    check(stopped_o == '0, "R7 idle after pulses", stopped_o, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule